// File: doc/BRIEF.md
# SPI Launch and Sample Timing Aligner

This block sits between the shift logic of a fast SPI master and its pins. It delays the outgoing MOSI bit and the incoming MISO bit by a chosen number of controller-clock cycles. It also moves the strobe that captures the returned bit, so that at high SCK rates the sample point can follow the round-trip delay through the pads and the slave. Each of the three adjustments is a 2-bit setting.

The settings come from one of two sources. In manual mode they are taken directly from three input fields. In automatic mode they are derived from a 2-bit SCK frequency class and from the SCK divider ratio. The working settings are loaded into a register only on clock edges where no transfer is in progress, so a running transfer always sees stable timing. The capture strobe has a built-in latency of two cycles. This lets it be moved two cycles earlier, one cycle earlier, or one cycle later than nominal. A one-bit sample register then takes the retimed MISO value whenever the adjusted strobe fires.

Top module: `spi_sample_align`

## Requirements
- R1: `mosi_out` equals `mosi_raw` delayed by `act_out_dly` clock cycles (0 to 3; 0 is a combinational pass-through).
- R2: `miso_retimed` equals `miso_in` delayed by `act_in_dly` clock cycles (0 to 3).
- R3: `cap_strobe` equals `strobe_in` delayed by `act_cap_sel` cycles. Code 2 is the nominal point (2-cycle latency), code 0 is two cycles earlier (no latency), code 1 is one cycle earlier and code 3 is one cycle later.
- R4: `sample_bit` loads `miso_retimed` on every clock edge where `cap_strobe` is 1 and holds its value on all other edges.
- R5: In manual mode (`auto_en`=0), an edge with `busy`=0 loads `man_out_dly`, `man_in_dly` and `man_cap_sel` into `act_out_dly`, `act_in_dly` and `act_cap_sel`, which are visible from the next cycle.
- R6: In automatic mode, an idle edge sets the capture code from `freq_class`: class 3 (100 MHz and up) gives 3, class 2 (80 MHz and up) gives 2, class 1 (40 MHz and up) gives 1, and class 0 (below 40 MHz) gives 0. For classes 1 to 3 the input delay is 0, and the output delay is always 0 in automatic mode.
- R7: In automatic mode with `freq_class`=0, the input delay is 3 when `div_ratio` is at least 16, 2 when it is at least 8, 1 when it is at least 6, and 0 below 6.
- R8: On an edge where `busy`=1, `act_out_dly`, `act_in_dly` and `act_cap_sel` keep their values whatever the mode, field, class or ratio inputs do.
- R9: While `rst_n`=0 the active settings, all delay stages and `sample_bit` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, applied on the clock edge |
| busy | input | 1 | A transfer is in progress; the settings are frozen |
| auto_en | input | 1 | 1 selects automatic settings, 0 selects the manual fields |
| man_out_dly | input | 2 | Manual MOSI delay in cycles |
| man_in_dly | input | 2 | Manual MISO delay in cycles |
| man_cap_sel | input | 2 | Manual capture code |
| freq_class | input | 2 | SCK frequency class: 0 <40, 1 >=40, 2 >=80, 3 >=100 MHz |
| div_ratio | input | DIV_W | Controller-clock to SCK divider ratio |
| mosi_raw | input | 1 | MOSI bit from the shifter |
| miso_in | input | 1 | MISO line |
| strobe_in | input | 1 | Nominal sample strobe |
| mosi_out | output | 1 | Delayed MOSI |
| miso_retimed | output | 1 | Delayed MISO |
| cap_strobe | output | 1 | Adjusted capture strobe |
| sample_bit | output | 1 | Captured MISO bit |
| act_out_dly | output | 2 | Active MOSI delay |
| act_in_dly | output | 2 | Active MISO delay |
| act_cap_sel | output | 2 | Active capture code |

## Verification
The delay and capture properties compare each output with a past value of its input. They therefore rely on `mosi_raw`, `miso_in` and `strobe_in` being held at 0 while reset is asserted, so that the cleared stages agree with the history that is looked back on. The freeze property relies on `busy` being a clean level that is sampled on the edge. The stimulus holds all data inputs at 0 during reset. After reset it changes every input only on the falling clock edge, toggling the data lines pseudo-randomly while sweeping the setting fields, the frequency classes and the divider values on either side of each threshold.

// File: rtl/spi_sa_pkg.sv
package spi_sa_pkg;

  localparam int unsigned SEL_W = 2;

  typedef struct packed {
    logic [SEL_W-1:0] out_dly;
    logic [SEL_W-1:0] in_dly;
    logic [SEL_W-1:0] cap_sel;
  } dly_cfg_t;

  // capture codes: value equals strobe latency in cycles
  localparam logic [SEL_W-1:0] CAP_EARLY2 = 2'd0;
  localparam logic [SEL_W-1:0] CAP_EARLY1 = 2'd1;
  localparam logic [SEL_W-1:0] CAP_NOM    = 2'd2;
  localparam logic [SEL_W-1:0] CAP_LATE1  = 2'd3;

  // frequency classes
  localparam logic [1:0] FC_LOW  = 2'd0;
  localparam logic [1:0] FC_MID  = 2'd1;
  localparam logic [1:0] FC_HIGH = 2'd2;
  localparam logic [1:0] FC_TOP  = 2'd3;

  function automatic dly_cfg_t auto_pick(input logic [1:0] fc,
                                         input int unsigned ratio,
                                         input int unsigned th_lo,
                                         input int unsigned th_mid,
                                         input int unsigned th_hi);
    dly_cfg_t r;
    r = '0;
    case (fc)
      FC_TOP:  r.cap_sel = CAP_LATE1;
      FC_HIGH: r.cap_sel = CAP_NOM;
      FC_MID:  r.cap_sel = CAP_EARLY1;
      default: begin
        r.cap_sel = CAP_EARLY2;
        if (ratio >= th_hi)       r.in_dly = 2'd3;
        else if (ratio >= th_mid) r.in_dly = 2'd2;
        else if (ratio >= th_lo)  r.in_dly = 2'd1;
        else                      r.in_dly = 2'd0;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sa_cfg_latch.sv
module sa_cfg_latch
  import spi_sa_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned TH_LO  = 6,
  parameter int unsigned TH_MID = 8,
  parameter int unsigned TH_HI  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             auto_en,
  input  dly_cfg_t         man_cfg,
  input  logic [1:0]       fclass,
  input  logic [DIV_W-1:0] ratio,
  output dly_cfg_t         act_cfg,
  output logic             cfg_load
);

  dly_cfg_t pick;

  always_comb begin
    if (auto_en) pick = auto_pick(fclass, 32'(ratio), TH_LO, TH_MID, TH_HI);
    else         pick = man_cfg;
  end

  assign cfg_load = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)        act_cfg <= '0;
    else if (cfg_load) act_cfg <= pick;
  end

endmodule

// File: rtl/sa_tap_line.sv
module sa_tap_line #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             dout
);

  localparam int unsigned DEPTH = (1 << SEL_W) - 1;

  logic [DEPTH-1:0] stg;
  logic [DEPTH:0]   tap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      for (int k = DEPTH - 1; k > 0; k--) stg[k] <= stg[k-1];
      stg[0] <= din;
    end
  end

  assign tap[0] = din;
  for (genvar k = 1; k <= DEPTH; k++) begin : g_tap
    assign tap[k] = stg[k-1];
  end

  assign dout = tap[sel];

endmodule

// File: rtl/spi_sample_align.sv
module spi_sample_align
  import spi_sa_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned TH_LO  = 6,
  parameter int unsigned TH_MID = 8,
  parameter int unsigned TH_HI  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             auto_en,
  input  logic [1:0]       man_out_dly,
  input  logic [1:0]       man_in_dly,
  input  logic [1:0]       man_cap_sel,
  input  logic [1:0]       freq_class,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             mosi_raw,
  input  logic             miso_in,
  input  logic             strobe_in,
  output logic             mosi_out,
  output logic             miso_retimed,
  output logic             cap_strobe,
  output logic             sample_bit,
  output logic [1:0]       act_out_dly,
  output logic [1:0]       act_in_dly,
  output logic [1:0]       act_cap_sel
);

  localparam int unsigned NUM_LANES = 3;

  dly_cfg_t man_cfg;
  dly_cfg_t act_cfg;
  logic     cfg_load;

  assign man_cfg = '{out_dly: man_out_dly, in_dly: man_in_dly, cap_sel: man_cap_sel};

  sa_cfg_latch #(
    .DIV_W(DIV_W), .TH_LO(TH_LO), .TH_MID(TH_MID), .TH_HI(TH_HI)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .auto_en (auto_en),
    .man_cfg (man_cfg),
    .fclass  (freq_class),
    .ratio   (div_ratio),
    .act_cfg (act_cfg),
    .cfg_load(cfg_load)
  );

  // lane 0: MOSI launch, lane 1: MISO retime, lane 2: capture strobe
  logic [NUM_LANES-1:0]            lane_din;
  logic [NUM_LANES-1:0]            lane_dout;
  logic [NUM_LANES-1:0][SEL_W-1:0] lane_sel;

  assign lane_din = {strobe_in, miso_in, mosi_raw};
  assign lane_sel = {act_cfg.cap_sel, act_cfg.in_dly, act_cfg.out_dly};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    sa_tap_line #(.SEL_W(SEL_W)) u_line (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (lane_din[g]),
      .sel  (lane_sel[g]),
      .dout (lane_dout[g])
    );
  end

  assign mosi_out     = lane_dout[0];
  assign miso_retimed = lane_dout[1];
  assign cap_strobe   = lane_dout[2];

  always_ff @(posedge clk) begin
    if (!rst_n)          sample_bit <= 1'b0;
    else if (cap_strobe) sample_bit <= miso_retimed;
  end

  assign act_out_dly = act_cfg.out_dly;
  assign act_in_dly  = act_cfg.in_dly;
  assign act_cap_sel = act_cfg.cap_sel;

endmodule

// File: rtl/sa_checker.sv
module sa_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mosi_raw,
  input logic       miso_in,
  input logic       strobe_in,
  input logic       mosi_out,
  input logic       miso_retimed,
  input logic       cap_strobe,
  input logic       sample_bit,
  input logic [1:0] act_out,
  input logic [1:0] act_in,
  input logic [1:0] act_cap
);

  AST_MOSI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_out == 2'd1) |-> (mosi_out == $past(mosi_raw))); // R1
  AST_MOSI_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_out == 2'd3) |-> (mosi_out == $past(mosi_raw, 3))); // R1
  AST_MISO_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (act_in == 2'd2) |-> (miso_retimed == $past(miso_in, 2))); // R2
  AST_CAP_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cap == 2'd2) |-> (cap_strobe == $past(strobe_in, 2))); // R3
  AST_CAP_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cap == 2'd3) |-> (cap_strobe == $past(strobe_in, 3))); // R3
  AST_SAMPLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_strobe) |-> (sample_bit == $past(miso_retimed))); // R4
  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_strobe) |-> $stable(sample_bit)); // R4
  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({act_out, act_in, act_cap})); // R8

endmodule

bind spi_sample_align sa_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .mosi_raw    (mosi_raw),
  .miso_in     (miso_in),
  .strobe_in   (strobe_in),
  .mosi_out    (mosi_out),
  .miso_retimed(miso_retimed),
  .cap_strobe  (cap_strobe),
  .sample_bit  (sample_bit),
  .act_out     (act_out_dly),
  .act_in      (act_in_dly),
  .act_cap     (act_cap_sel)
);

// File: tb/spi_sample_align_tb_top.sv
`timescale 1ns/1ps
module spi_sample_align_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0, auto_en = 1'b0;
  logic [1:0] man_out_dly = '0, man_in_dly = '0, man_cap_sel = '0, freq_class = '0;
  logic [7:0] div_ratio = '0;
  logic       mosi_raw = 1'b0, miso_in = 1'b0, strobe_in = 1'b0;
  logic       mosi_out, miso_retimed, cap_strobe, sample_bit;
  logic [1:0] act_out_dly, act_in_dly, act_cap_sel;

  always #4 clk = ~clk;

  spi_sample_align dut_i (.*);

  typedef struct {
    logic mo, mi, cs, sb;
    logic [1:0] ao, ai, ac;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  logic h_mo[4], h_mi[4], h_st[4];
  logic [1:0] m_out = 0, m_in = 0, m_cap = 0;
  logic m_smp = 0;

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // independent restatement of the automatic choice
  task automatic model_auto(input logic [1:0] fc, input int dv, output logic [1:0] i, output logic [1:0] c);
    c = fc;   // class code maps straight onto capture latency
    i = 0;
    if (fc == 0) begin
      if (dv < 6)       i = 0;
      else if (dv < 8)  i = 1;
      else if (dv < 16) i = 2;
      else              i = 3;
    end
  endtask

  task automatic drive(input logic b, input logic au, input logic [1:0] o, input logic [1:0] i,
                       input logic [1:0] c, input logic [1:0] fc, input logic [7:0] dv,
                       input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      logic [1:0] ni, nc;
      logic nsmp;
      @(negedge clk);
      busy = b; auto_en = au; man_out_dly = o; man_in_dly = i; man_cap_sel = c;
      freq_class = fc; div_ratio = dv;
      mosi_raw = 1'($urandom); miso_in = 1'($urandom); strobe_in = 1'($urandom);
      h_mo[0] = mosi_raw; h_mi[0] = miso_in; h_st[0] = strobe_in;
      #1;
      e.mo = h_mo[m_out]; e.mi = h_mi[m_in]; e.cs = h_st[m_cap]; e.sb = m_smp;
      e.ao = m_out; e.ai = m_in; e.ac = m_cap; e.tag = tag;
      q.push_back(e);
      nsmp = e.cs ? e.mi : m_smp;
      @(posedge clk);
      for (int s = 3; s > 0; s--) begin
        h_mo[s] = h_mo[s-1]; h_mi[s] = h_mi[s-1]; h_st[s] = h_st[s-1];
      end
      m_smp = nsmp;
      if (!b) begin
        if (au) begin
          model_auto(fc, int'(dv), ni, nc);
          m_out = 0; m_in = ni; m_cap = nc;
        end else begin
          m_out = o; m_in = i; m_cap = c;
        end
      end
    end
  endtask

  // monitor: pops expected items and compares mid-cycle
  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({1'b0, mosi_out},     {1'b0, e.mo}, "R1", "mosi_out");
      chk({1'b0, miso_retimed}, {1'b0, e.mi}, "R2", "miso_retimed");
      chk({1'b0, cap_strobe},   {1'b0, e.cs}, "R3", "cap_strobe");
      chk({1'b0, sample_bit},   {1'b0, e.sb}, "R4", "sample_bit");
      chk(act_out_dly, e.ao, e.tag, "act_out_dly");
      chk(act_in_dly,  e.ai, e.tag, "act_in_dly");
      chk(act_cap_sel, e.ac, e.tag, "act_cap_sel");
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int divs[8] = '{0, 5, 6, 7, 8, 15, 16, 255};
    for (int s = 0; s < 4; s++) begin h_mo[s] = 0; h_mi[s] = 0; h_st[s] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R9: reset state
    chk(act_out_dly, 2'd0, "R9", "act_out_dly after reset");
    chk(act_in_dly,  2'd0, "R9", "act_in_dly after reset");
    chk(act_cap_sel, 2'd0, "R9", "act_cap_sel after reset");
    chk({1'b0, sample_bit}, 2'd0, "R9", "sample_bit after reset");
    chk({1'b0, cap_strobe}, 2'd0, "R9", "cap_strobe after reset");

    // R5 manual sweep with R1-style delays on each lane
    for (int v = 0; v < 4; v++) begin
      drive(0, 0, 2'(v), 2'(v), 2'(v), 0, 0, "R5", 1);
      drive(1, 0, 2'(v), 2'(v), 2'(v), 0, 0, "R5", 12);
      drive(0, 0, 2'(v), 2'(3 - v), 2'(v + 1), 0, 0, "R5", 1);
      drive(1, 0, 2'(v), 2'(3 - v), 2'(v + 1), 0, 0, "R5", 12);
    end

    // R8: fields and mode move while busy
    drive(0, 0, 1, 2, 3, 0, 0, "R5", 1);
    drive(1, 0, 3, 0, 1, 2, 9, "R8", 6);
    drive(1, 1, 0, 3, 0, 0, 20, "R8", 6);
    drive(0, 1, 0, 3, 0, 0, 20, "R7", 1);
    drive(1, 0, 2, 2, 2, 3, 0, "R8", 6);

    // R6: frequency classes with junk in the manual fields
    for (int fc = 3; fc >= 0; fc--) begin
      drive(0, 1, 3, 3, 3, 2'(fc), 200, "R6", 1);
      drive(1, 1, 3, 3, 3, 2'(fc), 200, "R6", 10);
    end

    // R7: divider thresholds in the lowest class
    foreach (divs[d]) begin
      drive(0, 1, 2, 1, 3, 0, 8'(divs[d]), "R7", 1);
      drive(1, 1, 2, 1, 3, 0, 8'(divs[d]), "R7", 8);
    end

    drive(1, 0, 0, 0, 0, 0, 0, "R8", 4);
    @(negedge clk);
    #4;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule